// File: doc/BRIEF.md
# Write-Through Register File

This block is a general-purpose register file for a pipelined processor core. It holds 32 registers of 32 bits each. Two independent read ports return register contents combinationally, from an address presented in the same cycle. One write port stores data on the rising clock edge when its enable is high.

Within a single cycle the write is treated as coming before the reads. When a read port addresses the register that is being written in that same cycle, it returns the incoming write data rather than the stored, stale value. This matches a split-cycle scheme in which the first half of the cycle writes and the second half reads. A decode stage can therefore read an operand in the same cycle in which write-back produces it, with no extra forwarding path outside the block.

Register 0 is a constant zero. Writes to it are discarded, and a write to it never feeds a read port through the same-cycle path. No other register is cleared at start-up. The read and write ports are plain address/data pins with no valid/ready handshake: every cycle is a read on both ports and, optionally, a write. There is no back-pressure.

Top module: `regfile_wt`

## Requirements
- R1: Each read port drives, in the same cycle, the contents of the register selected by its own 5-bit address, with no clock edge in between. The two ports are independent of each other.
- R2: Address 0 always reads as zero on both ports. A write with address 0 changes nothing, and it is never passed through to a read port, even in the cycle of the write.
- R3: When the write enable is high at a rising clock edge and the write address is nonzero, that register holds the write data from then on. Reads in later cycles return that data.
- R4: When the write enable is low at a rising edge, no register changes, whatever the write address and write data are.
- R5: When the write enable is high and a read address equals a nonzero write address in the same cycle, that read port returns the write data before the edge.
- R6: The same-cycle pass-through works on each port on its own. Both ports may receive the write data in one cycle. One port may receive the write data while the other returns a different, stored register.
- R7: With the write enable low, a read address equal to the write address returns the stored value, not the write data.
- R8: A write to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Data to write |
| rd_a_addr | input | 5 | Register number for read port A |
| rd_a_data | output | 32 | Read data of port A (combinational) |
| rd_b_addr | input | 5 | Register number for read port B |
| rd_b_data | output | 32 | Read data of port B (combinational) |

## Verification
The two functions that meet in one cycle are the write to a register and the read of that same register. The bench provokes this by driving a nonzero write address, the write enable and new data in the same cycle as a matching read address on one or both ports. It samples the read data before the edge and expects the new data, while the other port, pointed at a different register, must still show its stored value. The same collision is repeated with the write enable low, and with write address 0, where the stored value or zero is expected instead. After the edge, reads check that the commit took place or was discarded as required.

// File: rtl/regfile_wt_pkg.sv
package regfile_wt_pkg;

  localparam int unsigned RF_ADDR_W = 5;
  localparam int unsigned RF_DATA_W = 32;

  // register 0 is hard-wired; every other index is a real storage cell
  function automatic logic addr_is_live(input int unsigned idx);
    return idx != 0;
  endfunction

endpackage

// File: rtl/regfile_wt_wsel.sv
module regfile_wt_wsel #(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:0]  sel
);
  import regfile_wt_pkg::*;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    if (addr_is_live(i)) begin : g_live
      assign sel[i] = wr_en && (wr_addr == ADDR_W'(i));
    end else begin : g_zero
      assign sel[i] = 1'b0;
    end
  end
endmodule

// File: rtl/regfile_wt_store.sv
module regfile_wt_store #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic [DEPTH-1:0]              sel,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  cells
);
  import regfile_wt_pkg::*;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (addr_is_live(i)) begin : g_live
      logic [DATA_W-1:0] value;
      always_ff @(posedge clk) begin
        if (sel[i]) value <= wr_data;
      end
      assign cells[i] = value;
    end else begin : g_zero
      // the select for this entry is tied low by the decoder
      logic unused_sel;
      assign unused_sel = sel[i];
      assign cells[i] = '0;
    end
  end
endmodule

// File: rtl/regfile_wt_rport.sv
module regfile_wt_rport #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0]  cells,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data
);
  import regfile_wt_pkg::*;

  logic hit;

  // same-cycle pass-through: the write is ordered ahead of the read
  always_comb begin
    hit = wr_en && (wr_addr == rd_addr) && addr_is_live(int'(rd_addr));
    rd_data = hit ? wr_data : cells[rd_addr];
  end
endmodule

// File: rtl/regfile_wt.sv
module regfile_wt #(
  parameter int unsigned ADDR_W = regfile_wt_pkg::RF_ADDR_W,
  parameter int unsigned DATA_W = regfile_wt_pkg::RF_DATA_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned NPORT = 2;

  logic [DEPTH-1:0]             sel;
  logic [DEPTH-1:0][DATA_W-1:0] cells;
  logic [NPORT-1:0][ADDR_W-1:0] raddr;
  logic [NPORT-1:0][DATA_W-1:0] rdata;

  regfile_wt_wsel #(.ADDR_W(ADDR_W)) u_wsel (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel     (sel)
  );

  regfile_wt_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .sel     (sel),
    .wr_data (wr_data),
    .cells   (cells)
  );

  assign raddr[0] = rd_a_addr;
  assign raddr[1] = rd_b_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_rport
    regfile_wt_rport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
      .cells   (cells),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (raddr[p]),
      .rd_data (rdata[p])
    );
  end

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];
endmodule

// File: rtl/regfile_wt_checker.sv
module regfile_wt_checker #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data
);
  // two edges must pass before $past refers to driven values
  logic [1:0] age = 2'd0;
  always_ff @(posedge clk) if (age != 2'd2) age <= age + 2'd1;
  logic armed;
  assign armed = (age == 2'd2);

  assert_zero_a_R2: assert property (@(posedge clk) disable iff (!armed)
    (rd_a_addr == '0) |-> (rd_a_data == '0));
  assert_zero_b_R2: assert property (@(posedge clk) disable iff (!armed)
    (rd_b_addr == '0) |-> (rd_b_data == '0));

  assert_pass_a_R5: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_addr != '0 && wr_addr == rd_a_addr) |-> (rd_a_data == wr_data));
  assert_pass_b_R6: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_addr != '0 && wr_addr == rd_b_addr) |-> (rd_b_data == wr_data));

  assert_commit_a_R3: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && wr_addr != '0) |=>
      ((rd_a_addr != $past(wr_addr)) || (wr_en && wr_addr == rd_a_addr) ||
       (rd_a_data == $past(wr_data))));

  assert_hold_a_R4: assert property (@(posedge clk) disable iff (!armed)
    (!$past(wr_en) && $stable(rd_a_addr) && !(wr_en && wr_addr == rd_a_addr))
      |-> $stable(rd_a_data));
  assert_hold_b_R4: assert property (@(posedge clk) disable iff (!armed)
    (!$past(wr_en) && $stable(rd_b_addr) && !(wr_en && wr_addr == rd_b_addr))
      |-> $stable(rd_b_data));
endmodule

bind regfile_wt regfile_wt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .rd_b_addr (rd_b_addr),
  .rd_b_data (rd_b_data)
);

// File: tb/regfile_wt_test.sv
`timescale 1ns/1ps
module regfile_wt_test;
  logic        clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_addr = '0;
  logic [31:0] rd_a_data;
  logic [4:0]  rd_b_addr = '0;
  logic [31:0] rd_b_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  regfile_wt uut (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  function automatic logic [31:0] pat(input int idx, input logic [7:0] salt);
    return {idx[7:0], ~idx[7:0], salt, idx[7:0] ^ salt};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // set up a cycle's inputs just after the falling edge
  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_a_addr = ra; rd_b_addr = rb;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    if (wr_en && wr_addr != 0) model[wr_addr] = wr_data;
  endtask

  task automatic t_zero();
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    chk("R2 reset read A", rd_a_data, 32'h0);
    chk("R2 reset read B", rd_b_data, 32'h0);
    drive(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0);
    chk("R2 no pass-through A", rd_a_data, 32'h0);
    chk("R2 no pass-through B", rd_b_data, 32'h0);
    commit();
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    chk("R2 after write A", rd_a_data, 32'h0);
  endtask

  task automatic t_fill();
    for (int i = 1; i < 32; i++) begin
      drive(1'b1, 5'(i), pat(i, 8'h3C), 5'd0, 5'd0);
      commit();
    end
    for (int i = 0; i < 32; i++) begin
      drive(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
      chk("R1 R3 port A", rd_a_data, (i == 0) ? 32'h0 : model[i]);
      chk("R1 R8 port B", rd_b_data, (i == 31) ? 32'h0 : model[31 - i]);
    end
  endtask

  task automatic t_hold();
    drive(1'b0, 5'd5, 32'h1234_5678, 5'd5, 5'd6);
    chk("R7 no pass-through when disabled", rd_a_data, model[5]);
    commit();
    drive(1'b0, 5'd0, 32'h0, 5'd5, 5'd6);
    chk("R4 no change without enable", rd_a_data, model[5]);
    chk("R4 neighbour", rd_b_data, model[6]);
  endtask

  task automatic t_bypass();
    drive(1'b1, 5'd7, 32'hCAFE_0007, 5'd7, 5'd8);
    chk("R5 pass-through A", rd_a_data, 32'hCAFE_0007);
    chk("R6 other port stored", rd_b_data, model[8]);
    drive(1'b1, 5'd7, 32'hCAFE_0007, 5'd7, 5'd7);
    chk("R6 both ports A", rd_a_data, 32'hCAFE_0007);
    chk("R6 both ports B", rd_b_data, 32'hCAFE_0007);
    commit();
    drive(1'b0, 5'd0, 32'h0, 5'd7, 5'd8);
    chk("R3 committed", rd_a_data, 32'hCAFE_0007);
    chk("R8 neighbour kept", rd_b_data, model[8]);
  endtask

  task automatic t_back2back();
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 5'd31, pat(k, 8'hA5), 5'd30, 5'd31);
      chk("R5 R6 back-to-back B", rd_b_data, pat(k, 8'hA5));
      chk("R8 back-to-back A", rd_a_data, model[30]);
      commit();
    end
    drive(1'b0, 5'd0, 32'h0, 5'd31, 5'd1);
    chk("R3 last write wins", rd_a_data, pat(3, 8'hA5));
    chk("R8 far register", rd_b_data, model[1]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    t_zero();
    t_fill();
    t_hold();
    t_bypass();
    t_back2back();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule